// File: doc/BRIEF.md
# SPI Serial Clock Divider

This block derives the serial clock of an SPI master from the system clock. The divide ratio N is the product of two selectable factors. A 2-bit code picks a small prime prescaler. A 4-bit code picks a scaler from a table that is uneven at its low end and runs in powers of two above that. A double-rate control halves the product. While the run enable is high, the block produces a continuous SCK with a period of exactly N system cycles. When N is odd, the low phase takes the extra cycle.

Each SCK transition comes with a one-cycle strobe: one strobe for the leading (rising) edge and one for the trailing (falling) edge. A shift register beside the block can shift and sample on these strobes without detecting edges itself. The divider settings are taken on the last cycle in which the enable is low. They stay frozen for the rest of the transfer.

Top module: `spi_sck_gen`

## Requirements
- R1: The prescaler code `pre_sel` maps 0, 1, 2, 3 to the factors 2, 3, 5, 7.
- R2: The scaler code `scl_sel` maps codes 0 to 3 to 2, 4, 6, 8. Codes 4 to 15 map to 2 to the power of the code (16 up to 32768).
- R3: With `dbl_rate` low, N = prescaler × scaler. Codes 0/0 give N = 4, codes 1/2 give N = 18, and codes 3/15 give N = 229376.
- R4: With `dbl_rate` high, N = prescaler × scaler / 2. The smallest case, N = 2, still toggles SCK every cycle.
- R5: The high phase of SCK lasts floor(N/2) system cycles and the low phase lasts ceil(N/2) cycles, so the period is exactly N. This holds for odd N as well.
- R6: While `run_en` is low, SCK is held low and the phase counter is cleared. Count the clock edges at which `run_en` is sampled high as 1, 2, 3 and so on. SCK goes high at edge ceil(N/2), then toggles by R5.
- R7: `lead_stb` is high for exactly the one cycle in which SCK has just risen. `trail_stb` is high for exactly the one cycle in which SCK has just fallen. The two are never high together.
- R8: The selects and `dbl_rate` are captured on the last clock edge at which `run_en` is low. Changes while `run_en` is high are ignored, including a change made in the same cycle that `run_en` rises. The captured settings apply until the next transfer.
- R9: A clock edge that samples `run_en` low forces SCK low and both strobes low. This holds even when an edge was due at that clock, so no trailing strobe is given.
- R10: While `rst` is high, SCK and both strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pre_sel | input | 2 | Prescaler code (R1) |
| scl_sel | input | 4 | Scaler code (R2) |
| dbl_rate | input | 1 | Halve the divide ratio when high |
| run_en | input | 1 | Run SCK while high (transfer in progress) |
| sck | output | 1 | Serial clock, idle low |
| lead_stb | output | 1 | One-cycle pulse with each rising SCK edge |
| trail_stb | output | 1 | One-cycle pulse with each falling SCK edge |

## Verification
Two functions can land in the same cycle. Settings capture can coincide with the start of a transfer, and disabling can coincide with an edge that is due. The bench changes the selects on the very cycle that `run_en` rises. It then judges the whole waveform against the ratio of the old settings. The bench also drops `run_en` just before the edge on which a trailing edge is scheduled, and again in the middle of a high phase. In both cases it requires SCK low with no strobe after that edge.

// File: rtl/spi_clkdiv_pkg.sv
package spi_clkdiv_pkg;

    localparam int PRE_SEL_W = 2;
    localparam int SCL_SEL_W = 4;
    localparam int PRE_F_W   = 3;
    localparam int SCL_F_W   = 16;
    localparam int MAX_RATIO = 7 * 32768;
    localparam int RATIO_W   = $clog2(MAX_RATIO + 1);

    typedef struct packed {
        logic [PRE_SEL_W-1:0] pre_sel;
        logic [SCL_SEL_W-1:0] scl_sel;
        logic                 dbl;
    } div_cfg_t;

    typedef struct packed {
        logic [RATIO_W-1:0] hi_len;
        logic [RATIO_W-1:0] lo_len;
    } phase_t;

    typedef enum logic {
        SCK_IDLE   = 1'b0,
        SCK_ACTIVE = 1'b1
    } sck_lvl_t;

    localparam div_cfg_t CFG_RESET = '{pre_sel: '0, scl_sel: '0, dbl: 1'b0};

    function automatic logic [PRE_F_W-1:0] pre_factor(input logic [PRE_SEL_W-1:0] code);
        case (code)
            2'd0:    return 3'd2;
            2'd1:    return 3'd3;
            2'd2:    return 3'd5;
            default: return 3'd7;
        endcase
    endfunction

    function automatic logic [SCL_F_W-1:0] scl_factor(input logic [SCL_SEL_W-1:0] code);
        logic [SCL_F_W-1:0] f;
        if (code < 4'd4)
            f = SCL_F_W'({code, 1'b0}) + SCL_F_W'(2);
        else
            f = SCL_F_W'(1) << code;
        return f;
    endfunction

    function automatic logic [RATIO_W-1:0] div_ratio(input div_cfg_t c);
        logic [RATIO_W-1:0] prod;
        prod = RATIO_W'(pre_factor(c.pre_sel)) * RATIO_W'(scl_factor(c.scl_sel));
        return c.dbl ? (prod >> 1) : prod;
    endfunction

    function automatic phase_t split_phases(input logic [RATIO_W-1:0] n);
        phase_t p;
        p.hi_len = n >> 1;
        p.lo_len = n - p.hi_len;
        return p;
    endfunction

endpackage

// File: rtl/spi_div_cfg_hold.sv
module spi_div_cfg_hold
    import spi_clkdiv_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     run_en,
    input  div_cfg_t cfg_in,
    output div_cfg_t cfg_q
);
    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= CFG_RESET;
        else if (!run_en)
            cfg_q <= cfg_in;
    end
endmodule

// File: rtl/spi_div_phase_calc.sv
module spi_div_phase_calc
    import spi_clkdiv_pkg::*;
(
    input  div_cfg_t cfg,
    output phase_t   phases
);
    logic [RATIO_W-1:0] ratio;

    always_comb begin
        ratio  = div_ratio(cfg);
        phases = split_phases(ratio);
    end
endmodule

// File: rtl/spi_div_engine.sv
module spi_div_engine
    import spi_clkdiv_pkg::*;
#(
    parameter int W = RATIO_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run_en,
    input  logic [W-1:0] hi_len,
    input  logic [W-1:0] lo_len,
    output logic         sck,
    output logic         lead_stb,
    output logic         trail_stb
);
    sck_lvl_t     lvl;
    logic [W-1:0] cnt;
    logic [W-1:0] cur_len;
    logic         hit;

    always_comb begin
        cur_len = (lvl == SCK_ACTIVE) ? hi_len : lo_len;
        hit     = (cnt == cur_len - W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst || !run_en) begin
            cnt       <= '0;
            lvl       <= SCK_IDLE;
            lead_stb  <= 1'b0;
            trail_stb <= 1'b0;
        end else if (hit) begin
            cnt       <= '0;
            lvl       <= (lvl == SCK_ACTIVE) ? SCK_IDLE : SCK_ACTIVE;
            lead_stb  <= (lvl == SCK_IDLE);
            trail_stb <= (lvl == SCK_ACTIVE);
        end else begin
            cnt       <= cnt + W'(1);
            lead_stb  <= 1'b0;
            trail_stb <= 1'b0;
        end
    end

    assign sck = (lvl == SCK_ACTIVE);
endmodule

// File: rtl/spi_sck_gen.sv
module spi_sck_gen
    import spi_clkdiv_pkg::*;
#(
    parameter int CNT_W = RATIO_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [PRE_SEL_W-1:0] pre_sel,
    input  logic [SCL_SEL_W-1:0] scl_sel,
    input  logic                 dbl_rate,
    input  logic                 run_en,
    output logic                 sck,
    output logic                 lead_stb,
    output logic                 trail_stb
);
    div_cfg_t cfg_live;
    div_cfg_t cfg_held;
    phase_t   phases;

    assign cfg_live = '{pre_sel: pre_sel, scl_sel: scl_sel, dbl: dbl_rate};

    spi_div_cfg_hold u_hold (
        .clk    (clk),
        .rst    (rst),
        .run_en (run_en),
        .cfg_in (cfg_live),
        .cfg_q  (cfg_held)
    );

    spi_div_phase_calc u_calc (
        .cfg    (cfg_held),
        .phases (phases)
    );

    spi_div_engine #(.W(CNT_W)) u_engine (
        .clk       (clk),
        .rst       (rst),
        .run_en    (run_en),
        .hi_len    (CNT_W'(phases.hi_len)),
        .lo_len    (CNT_W'(phases.lo_len)),
        .sck       (sck),
        .lead_stb  (lead_stb),
        .trail_stb (trail_stb)
    );
endmodule

// File: rtl/spi_sck_gen_chk.sv
module spi_sck_gen_chk
    import spi_clkdiv_pkg::*;
(
    input logic     clk,
    input logic     rst,
    input logic     run_en,
    input logic     sck,
    input logic     lead_stb,
    input logic     trail_stb,
    input div_cfg_t cfg_held
);
    logic [RATIO_W-1:0] run_len;
    phase_t             exp_ph;

    always_comb exp_ph = split_phases(div_ratio(cfg_held));

    always_ff @(posedge clk) begin
        if (rst || !run_en)
            run_len <= '0;
        else if (lead_stb || trail_stb)
            run_len <= RATIO_W'(1);
        else
            run_len <= run_len + RATIO_W'(1);
    end

    a_r10_reset_quiet: assert property (@(posedge clk)
        rst |=> (!sck && !lead_stb && !trail_stb));

    a_r9_idle_after_disable: assert property (@(posedge clk) disable iff (rst)
        !run_en |=> (!sck && !lead_stb && !trail_stb));

    a_r7_lead_on_rise: assert property (@(posedge clk) disable iff (rst)
        lead_stb |-> (sck && !$past(sck)));

    a_r7_trail_on_fall: assert property (@(posedge clk) disable iff (rst)
        trail_stb |-> (!sck && $past(sck)));

    a_r7_rise_has_strobe: assert property (@(posedge clk) disable iff (rst)
        (sck && !$past(sck)) |-> lead_stb);

    a_r7_one_strobe: assert property (@(posedge clk) disable iff (rst)
        $onehot0({lead_stb, trail_stb}));

    a_r8_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
        (run_en && $past(run_en)) |-> $stable(cfg_held));

    a_r5_low_phase_len: assert property (@(posedge clk) disable iff (rst)
        lead_stb |-> (run_len == exp_ph.lo_len));

    a_r5_high_phase_len: assert property (@(posedge clk) disable iff (rst)
        trail_stb |-> (run_len == exp_ph.hi_len));
endmodule

bind spi_sck_gen spi_sck_gen_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .run_en    (run_en),
    .sck       (sck),
    .lead_stb  (lead_stb),
    .trail_stb (trail_stb),
    .cfg_held  (cfg_held)
);

// File: tb/spi_sck_gen_bench.sv
module spi_sck_gen_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] pre_sel = '0;
    logic [3:0] scl_sel = '0;
    logic       dbl_rate = 1'b0;
    logic       run_en = 1'b0;
    logic       sck, lead_stb, trail_stb;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    spi_sck_gen u_spi_sck_gen (
        .clk(clk), .rst(rst), .pre_sel(pre_sel), .scl_sel(scl_sel),
        .dbl_rate(dbl_rate), .run_en(run_en),
        .sck(sck), .lead_stb(lead_stb), .trail_stb(trail_stb)
    );

    function automatic int ref_pre(input logic [1:0] c);
        case (c)
            2'd0: return 2;
            2'd1: return 3;
            2'd2: return 5;
            default: return 7;
        endcase
    endfunction

    function automatic int ref_scl(input logic [3:0] c);
        int tbl[4] = '{2, 4, 6, 8};
        if (c < 4) return tbl[c];
        return 1 << c;
    endfunction

    function automatic int ref_ratio(input logic [1:0] p, input logic [3:0] s, input logic d);
        int n = ref_pre(p) * ref_scl(s);
        return d ? n / 2 : n;
    endfunction

    // expected {sck, lead, trail} after the c-th enabled edge
    function automatic logic [2:0] ref_bits(input int n, input int c);
        int hi = n / 2;
        int lo = n - hi;
        int dd = c - lo;
        int m;
        if (dd < 0) return 3'b000;
        m = dd % n;
        return {m < hi, m == 0, m == hi};
    endfunction

    task automatic check(input bit ok, input string rq, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    // chg_at < 0: no select change; 0: change on the cycle enable rises; >0: after that edge
    task automatic transfer(input logic [1:0] p, input logic [3:0] s, input logic d,
                            input int ncyc, input int chg_at, input string rq);
        int n = ref_ratio(p, s, d);
        int bad_c = -1;
        logic [2:0] bad_a = '0, bad_e = '0;
        @(negedge clk);
        run_en = 1'b0; pre_sel = p; scl_sel = s; dbl_rate = d;
        @(negedge clk);
        run_en = 1'b1;
        if (chg_at == 0) begin pre_sel = ~p; scl_sel = ~s; dbl_rate = ~d; end
        for (int c = 1; c <= ncyc; c++) begin
            @(negedge clk);
            if (bad_c < 0 && {sck, lead_stb, trail_stb} !== ref_bits(n, c)) begin
                bad_c = c; bad_a = {sck, lead_stb, trail_stb}; bad_e = ref_bits(n, c);
            end
            if (c == chg_at) begin
                pre_sel = ~p; scl_sel = $urandom_range(0, 15); dbl_rate = ~d;
            end
        end
        if (bad_c >= 0)
            $display("FAIL %s mismatch at enabled edge %0d (N=%0d)", rq, bad_c, n);
        check(bad_c < 0, rq, "waveform {sck,lead,trail}", bad_a, bad_e);
        run_en = 1'b0;
        @(negedge clk);
        check({sck, lead_stb, trail_stb} == 3'b000, "R6", "idle after transfer",
              {sck, lead_stb, trail_stb}, 0);
    endtask

    // run for cut edges, then disable; the next edge must leave everything low
    task automatic abort_at(input logic [1:0] p, input logic [3:0] s, input logic d,
                            input int cut, input string what);
        int n = ref_ratio(p, s, d);
        @(negedge clk);
        run_en = 1'b0; pre_sel = p; scl_sel = s; dbl_rate = d;
        @(negedge clk);
        run_en = 1'b1;
        for (int c = 1; c <= cut; c++) @(negedge clk);
        check({sck, lead_stb, trail_stb} == ref_bits(n, cut), "R9", {what, " pre-state"},
              {sck, lead_stb, trail_stb}, ref_bits(n, cut));
        run_en = 1'b0;
        @(negedge clk);
        check({sck, lead_stb, trail_stb} == 3'b000, "R9", what,
              {sck, lead_stb, trail_stb}, 0);
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int n_r;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check({sck, lead_stb, trail_stb} == 3'b000, "R10", "outputs in reset",
              {sck, lead_stb, trail_stb}, 0);
        run_en = 1'b1;
        @(negedge clk);
        check({sck, lead_stb, trail_stb} == 3'b000, "R10", "enable ignored in reset",
              {sck, lead_stb, trail_stb}, 0);
        rst = 1'b0; run_en = 1'b0;
        @(negedge clk);

        // R3: fastest plain ratio N=4 and the 3x6 case N=18
        transfer(2'd0, 4'd0, 1'b0, 14, -1, "R3");
        transfer(2'd1, 4'd2, 1'b0, 40, -1, "R3");
        // R4: smallest ratio N=2, and odd N=3 (R5)
        transfer(2'd0, 4'd0, 1'b1, 9, -1, "R4");
        transfer(2'd1, 4'd0, 1'b1, 11, -1, "R5");
        // R5: odd N=21 (7x6/2) and N=15 (5x6/2)
        transfer(2'd3, 4'd2, 1'b1, 50, -1, "R5");
        transfer(2'd2, 4'd2, 1'b1, 35, -1, "R5");
        // R1: each prescaler code with scaler 8
        for (int k = 0; k < 4; k++)
            transfer(2'(k), 4'd3, 1'b0, 2 * ref_ratio(2'(k), 4'd3, 1'b0) + 2, -1, "R1");
        // R2: scaler codes 4..6 with prescaler 2
        for (int k = 4; k < 7; k++)
            transfer(2'd0, 4'(k), 1'b0, 2 * ref_ratio(2'd0, 4'(k), 1'b0) + 2, -1, "R2");
        // R8: change in the same cycle enable rises, and mid-transfer
        transfer(2'd2, 4'd1, 1'b0, 45, 0, "R8");
        transfer(2'd1, 4'd3, 1'b1, 60, 7, "R8");
        // R9: disable when a trailing edge is due (N=8: fall at edge 8) and mid-high
        abort_at(2'd0, 4'd1, 1'b0, 7, "disable on due trailing edge");
        abort_at(2'd0, 4'd1, 1'b0, 5, "disable mid high phase");
        // R6: first rise after ceil(N/2) edges with N=9 (3x6/2)
        transfer(2'd1, 4'd2, 1'b1, 6, -1, "R6");
        // random mix
        for (int k = 0; k < 20; k++) begin
            logic [1:0] rp = 2'($urandom_range(0, 3));
            logic [3:0] rs = 4'($urandom_range(0, 5));
            logic       rd = 1'($urandom_range(0, 1));
            n_r = ref_ratio(rp, rs, rd);
            transfer(rp, rs, rd, 2 * n_r + 3, (k % 3 == 0) ? 3 : -1, "R5");
        end
        // R3: largest ratio 229376, first rise at edge 114688
        transfer(2'd3, 4'd15, 1'b0, 114690, -1, "R3");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule